// File: doc/BRIEF.md
# Message Queue Port Unit

The unit passes 32-bit message frame addresses between a host bus and a local processor through four circular queues: inbound free, inbound post, outbound post and outbound free. Each queue holds `DEPTH` entries and has one producer and one consumer. The local processor fills the inbound free and outbound post queues and drains the inbound post and outbound free queues through dedicated push and pop ports. The host reaches the other end of every queue through two port registers. A read of a port register takes from one queue and a write to the same address feeds a different queue.

Accesses arrive on one register bus. A side bit tells whether the host or the local processor made the access. The queue ports and the message status register answer only the host. The local processor posts notifications by writing one of two outbound message registers. Each such write sets a status bit that the host clears by writing 1 to it. The host interrupt is raised while any status bit is set and enabled.

Top module: `mq_port_unit`

## Requirements
- R1: After reset all queues are empty, both outbound message registers and the message status read 0, the overflow flags read 0, the enable register reads 3 and `host_irq` is low.
- R2: A host read of address 0 returns the oldest inbound free entry and removes it. A host write to address 0 appends the data to the inbound post queue, which the local side drains in the same order.
- R3: A host read of address 1 returns the oldest outbound post entry and removes it. A host write to address 1 appends the data to the outbound free queue, which the local side drains in the same order.
- R4: A read from an empty queue returns 0xFFFFFFFF and removes nothing. This covers host port reads and the local pop data outputs, which show the head entry or 0xFFFFFFFF when the queue is empty.
- R5: A push to a full queue is dropped and sets sticky overflow bit q at address 6 (bit 0 inbound free, bit 1 inbound post, bit 2 outbound post, bit 3 outbound free). Either side clears a bit by writing 1 to it.
- R6: A push and a pop on the same queue in the same cycle both take effect. On a full queue the push is accepted because the pop frees a slot. On an empty queue the pop returns 0xFFFFFFFF and the push is stored.
- R7: A local-side access to address 0, 1 or 2 reads 0 and moves no queue. A local write to these addresses changes nothing.
- R8: A local write to address 4 or 5 stores the word in outbound message register 0 or 1 and sets status bit 0 or 1. Both sides read back the stored word, and host writes to addresses 4 and 5 are ignored.
- R9: A host write to address 2 clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R10: `host_irq` is high exactly while a status bit is set whose enable bit is set. The enable register is at address 3, bits [1:0], and either side may read or write it.
- R11: Each queue keeps first-in first-out order across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_host | input | 1 | 1 host side, 0 local side |
| req_addr | input | 3 | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, same cycle as the request, 0 when no read |
| lp_ifree_push | input | 1 | Local push to inbound free queue |
| lp_ifree_data | input | DATA_W | Data for that push |
| lp_ifree_full | output | 1 | Inbound free queue full |
| lp_opost_push | input | 1 | Local push to outbound post queue |
| lp_opost_data | input | DATA_W | Data for that push |
| lp_opost_full | output | 1 | Outbound post queue full |
| lp_ipost_pop | input | 1 | Local pop from inbound post queue |
| lp_ipost_data | output | DATA_W | Inbound post head, 0xFFFFFFFF when empty |
| lp_ipost_empty | output | 1 | Inbound post queue empty |
| lp_ofree_pop | input | 1 | Local pop from outbound free queue |
| lp_ofree_data | output | DATA_W | Outbound free head, 0xFFFFFFFF when empty |
| lp_ofree_empty | output | 1 | Outbound free queue empty |
| host_irq | output | 1 | Host interrupt |

## Verification
Two things can land on the same queue in one cycle: a host port access and a local push or pop. The bench produces this on purpose in two cases. It makes a host read of address 0 while the local side pushes into a full inbound free queue, and it makes a host write of address 0 while the local side pops an empty inbound post queue. A long phase of mixed random traffic then produces the same overlap on all four queues. Each cycle is judged against a behavioural queue model, which decides what is accepted, what is dropped and which overflow bit is set. That result is compared with read data, head words, full and empty flags, and the interrupt.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int unsigned NUM_Q   = 4;
  localparam int unsigned NUM_MSG = 2;
  localparam int unsigned ADDR_W  = 3;

  localparam int unsigned Q_IFREE = 0;
  localparam int unsigned Q_IPOST = 1;
  localparam int unsigned Q_OPOST = 2;
  localparam int unsigned Q_OFREE = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_IN_PORT  = 3'd0,
    A_OUT_PORT = 3'd1,
    A_MSG_STAT = 3'd2,
    A_MSG_EN   = 3'd3,
    A_OMSG0    = 3'd4,
    A_OMSG1    = 3'd5,
    A_OVF      = 3'd6,
    A_RSVD     = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic               rd_en;
    logic               rd_host;
    reg_addr_e          rd_sel;
    logic               in_port_rd;
    logic               in_port_wr;
    logic               out_port_rd;
    logic               out_port_wr;
    logic               stat_clr;
    logic               en_wr;
    logic               ovf_clr;
    logic [NUM_MSG-1:0] msg_wr;
  } acc_dec_s;
endpackage

// File: rtl/mq_rst_sync.sv
module mq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mq_decode.sv
module mq_decode
  import mq_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_host,
  input  logic [ADDR_W-1:0] req_addr,
  output acc_dec_s          dec
);
  logic rd;
  logic wr;

  always_comb begin
    rd = req_valid & ~req_write;
    wr = req_valid &  req_write;

    dec             = '0;
    dec.rd_en       = rd;
    dec.rd_host     = req_host;
    dec.rd_sel      = reg_addr_e'(req_addr);
    dec.in_port_rd  = rd & req_host & (req_addr == A_IN_PORT);
    dec.in_port_wr  = wr & req_host & (req_addr == A_IN_PORT);
    dec.out_port_rd = rd & req_host & (req_addr == A_OUT_PORT);
    dec.out_port_wr = wr & req_host & (req_addr == A_OUT_PORT);
    dec.stat_clr    = wr & req_host & (req_addr == A_MSG_STAT);
    dec.en_wr       = wr & (req_addr == A_MSG_EN);
    dec.ovf_clr     = wr & (req_addr == A_OVF);
    for (int m = 0; m < NUM_MSG; m++) begin
      dec.msg_wr[m] = wr & ~req_host &
                      (req_addr == ADDR_W'(int'(A_OMSG0) + m));
    end
  end
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo #(
  parameter  int unsigned DW    = 32,
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head_data,
  output logic          push_drop,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_n;
  logic [AW-1:0] rd_ptr, rd_ptr_n;
  logic [LW-1:0] level_n;
  logic          pop_ok;
  logic          push_ok;

  always_comb begin
    empty     = (level == '0);
    full      = (level == LW'(DEPTH));
    pop_ok    = pop_req & ~empty;
    push_ok   = push_req & (~full | pop_ok);
    push_drop = push_req & ~push_ok;
    head_data = empty ? '1 : mem[rd_ptr];

    wr_ptr_n = wr_ptr;
    if (push_ok) wr_ptr_n = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    rd_ptr_n = rd_ptr;
    if (pop_ok)  rd_ptr_n = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;

    case ({push_ok, pop_ok})
      2'b10:   level_n = level + 1'b1;
      2'b01:   level_n = level - 1'b1;
      default: level_n = level;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      level  <= level_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/mq_status.sv
module mq_status
  import mq_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_MSG-1:0]           msg_wr,
  input  logic                         stat_clr,
  input  logic                         en_wr,
  input  logic                         ovf_clr,
  input  logic [DW-1:0]                wdata,
  input  logic [NUM_Q-1:0]             q_drop,
  output logic [NUM_MSG-1:0][DW-1:0]   omsg,
  output logic [NUM_MSG-1:0]           msg_stat,
  output logic [NUM_MSG-1:0]           msg_en,
  output logic [NUM_Q-1:0]             ovf,
  output logic                         host_irq
);
  logic [NUM_MSG-1:0] stat_n;
  logic [NUM_MSG-1:0] en_n;
  logic [NUM_Q-1:0]   ovf_n;

  always_comb begin
    for (int m = 0; m < NUM_MSG; m++) begin
      stat_n[m] = msg_wr[m] | (msg_stat[m] & ~(stat_clr & wdata[m]));
    end
    en_n  = en_wr ? wdata[NUM_MSG-1:0] : msg_en;
    ovf_n = (ovf & ~({NUM_Q{ovf_clr}} & wdata[NUM_Q-1:0])) | q_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_stat <= '0;
      msg_en   <= '1;
      ovf      <= '0;
    end else begin
      msg_stat <= stat_n;
      msg_en   <= en_n;
      ovf      <= ovf_n;
    end
  end

  for (genvar m = 0; m < NUM_MSG; m++) begin : g_msg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         omsg[m] <= '0;
      else if (msg_wr[m]) omsg[m] <= wdata;
    end
  end

  assign host_irq = |(msg_stat & msg_en);
endmodule

// File: rtl/mq_port_unit.sv
module mq_port_unit
  import mq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_host,
  input  logic [2:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              lp_ifree_push,
  input  logic [DATA_W-1:0] lp_ifree_data,
  output logic              lp_ifree_full,
  input  logic              lp_opost_push,
  input  logic [DATA_W-1:0] lp_opost_data,
  output logic              lp_opost_full,
  input  logic              lp_ipost_pop,
  output logic [DATA_W-1:0] lp_ipost_data,
  output logic              lp_ipost_empty,
  input  logic              lp_ofree_pop,
  output logic [DATA_W-1:0] lp_ofree_data,
  output logic              lp_ofree_empty,
  output logic              host_irq
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic                              rst_n_sync;
  acc_dec_s                          dec;
  logic [NUM_Q-1:0]                  q_push, q_pop, q_drop, q_empty, q_full;
  logic [NUM_Q-1:0][DATA_W-1:0]      q_wdata, q_head;
  logic [NUM_Q-1:0][LVL_W-1:0]       q_level;
  logic [NUM_MSG-1:0][DATA_W-1:0]    omsg;
  logic [NUM_MSG-1:0]                msg_stat, msg_en;
  logic [NUM_Q-1:0]                  ovf;
  logic [DATA_W-1:0]                 rdata_n;

  mq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  mq_decode u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_host  (req_host),
    .req_addr  (req_addr),
    .dec       (dec)
  );

  // queue steering: each queue has one producer and one consumer
  always_comb begin
    q_push[Q_IFREE]  = lp_ifree_push;
    q_wdata[Q_IFREE] = lp_ifree_data;
    q_pop[Q_IFREE]   = dec.in_port_rd;

    q_push[Q_IPOST]  = dec.in_port_wr;
    q_wdata[Q_IPOST] = req_wdata;
    q_pop[Q_IPOST]   = lp_ipost_pop;

    q_push[Q_OPOST]  = lp_opost_push;
    q_wdata[Q_OPOST] = lp_opost_data;
    q_pop[Q_OPOST]   = dec.out_port_rd;

    q_push[Q_OFREE]  = dec.out_port_wr;
    q_wdata[Q_OFREE] = req_wdata;
    q_pop[Q_OFREE]   = lp_ofree_pop;
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    mq_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .push_req  (q_push[q]),
      .push_data (q_wdata[q]),
      .pop_req   (q_pop[q]),
      .head_data (q_head[q]),
      .push_drop (q_drop[q]),
      .level     (q_level[q]),
      .empty     (q_empty[q]),
      .full      (q_full[q])
    );
  end

  mq_status #(.DW(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .msg_wr   (dec.msg_wr),
    .stat_clr (dec.stat_clr),
    .en_wr    (dec.en_wr),
    .ovf_clr  (dec.ovf_clr),
    .wdata    (req_wdata),
    .q_drop   (q_drop),
    .omsg     (omsg),
    .msg_stat (msg_stat),
    .msg_en   (msg_en),
    .ovf      (ovf),
    .host_irq (host_irq)
  );

  always_comb begin
    rdata_n = '0;
    if (dec.rd_en) begin
      case (dec.rd_sel)
        A_IN_PORT:  if (dec.rd_host) rdata_n = q_head[Q_IFREE];
        A_OUT_PORT: if (dec.rd_host) rdata_n = q_head[Q_OPOST];
        A_MSG_STAT: if (dec.rd_host) rdata_n = DATA_W'(msg_stat);
        A_MSG_EN:   rdata_n = DATA_W'(msg_en);
        A_OMSG0:    rdata_n = omsg[0];
        A_OMSG1:    rdata_n = omsg[1];
        A_OVF:      rdata_n = DATA_W'(ovf);
        default:    rdata_n = '0;
      endcase
    end
  end

  assign rsp_rdata      = rdata_n;
  assign lp_ifree_full  = q_full[Q_IFREE];
  assign lp_opost_full  = q_full[Q_OPOST];
  assign lp_ipost_data  = q_head[Q_IPOST];
  assign lp_ipost_empty = q_empty[Q_IPOST];
  assign lp_ofree_data  = q_head[Q_OFREE];
  assign lp_ofree_empty = q_empty[Q_OFREE];
endmodule

// File: rtl/mq_port_unit_chk.sv
module mq_port_unit_chk
  import mq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LVL_W  = 5
) (
  input logic                        clk,
  input logic                        rst_n_sync,
  input logic                        req_valid,
  input logic                        req_write,
  input logic                        req_host,
  input logic [2:0]                  req_addr,
  input logic [DATA_W-1:0]           req_wdata,
  input logic [DATA_W-1:0]           rsp_rdata,
  input logic                        lp_ifree_push,
  input logic [NUM_MSG-1:0]          msg_stat,
  input logic [NUM_Q-1:0]            ovf,
  input logic [NUM_Q-1:0]            q_empty,
  input logic [NUM_Q-1:0]            q_full,
  input logic [NUM_Q-1:0][LVL_W-1:0] q_level,
  input logic                        host_irq
);
  logic host_rd, loc_acc, ovf_wr;
  assign host_rd = req_valid & ~req_write & req_host;
  assign loc_acc = req_valid & ~req_host;
  assign ovf_wr  = req_valid & req_write & (req_addr == A_OVF);

  // R4: empty port reads
  a_r4_empty_in_port: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (host_rd && req_addr == A_IN_PORT && q_empty[Q_IFREE]) |-> (rsp_rdata == '1));
  a_r4_empty_out_port: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (host_rd && req_addr == A_OUT_PORT && q_empty[Q_OPOST]) |-> (rsp_rdata == '1));

  // R7: local accesses to host-only registers
  a_r7_local_reads_zero: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (loc_acc && !req_write && req_addr <= A_MSG_STAT) |-> (rsp_rdata == '0));
  a_r7_local_no_pop: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (loc_acc && req_addr == A_IN_PORT && !lp_ifree_push) |=>
      (q_level[Q_IFREE] == $past(q_level[Q_IFREE])));

  // R8: a status bit only rises after a local message write
  a_r8_stat_cause: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(msg_stat[0]) |-> $past(loc_acc && req_write && req_addr == A_OMSG0));

  // R9: write-one-to-clear
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && req_write && req_host && req_addr == A_MSG_STAT && req_wdata[0])
      |=> !msg_stat[0]);

  // R5: overflow flags are sticky
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !ovf_wr |=> ((ovf & $past(ovf)) == $past(ovf)));

  // R10: interrupt needs a pending status bit
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n_sync)
    host_irq |-> (msg_stat != '0));

  for (genvar q = 0; q < NUM_Q; q++) begin : g_lvl
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n_sync)
      q_level[q] <= LVL_W'(DEPTH));
    a_r6_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n_sync)
      !(q_empty[q] && q_full[q]));
  end
endmodule

bind mq_port_unit mq_port_unit_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .LVL_W  (LVL_W)
) u_chk (
  .clk           (clk),
  .rst_n_sync    (rst_n_sync),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_host      (req_host),
  .req_addr      (req_addr),
  .req_wdata     (req_wdata),
  .rsp_rdata     (rsp_rdata),
  .lp_ifree_push (lp_ifree_push),
  .msg_stat      (msg_stat),
  .ovf           (ovf),
  .q_empty       (q_empty),
  .q_full        (q_full),
  .q_level       (q_level),
  .host_irq      (host_irq)
);

// File: tb/mq_port_unit_bench.sv
module mq_port_unit_bench;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write, req_host;
  logic [2:0]    req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata;
  logic          lp_ifree_push, lp_ifree_full;
  logic [DW-1:0] lp_ifree_data;
  logic          lp_opost_push, lp_opost_full;
  logic [DW-1:0] lp_opost_data;
  logic          lp_ipost_pop, lp_ipost_empty;
  logic [DW-1:0] lp_ipost_data;
  logic          lp_ofree_pop, lp_ofree_empty;
  logic [DW-1:0] lp_ofree_data;
  logic          host_irq;

  mq_port_unit #(.DATA_W(DW), .DEPTH(DEPTH)) u_mq_port_unit (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_run = 0;
  int    n_fail = 0;
  string cur_tag = "R1";

  // behavioural model: 0 ifree, 1 ipost, 2 opost, 3 ofree
  logic [DW-1:0] mdl_q [4][$];
  logic [DW-1:0] m_msg [2];
  logic [1:0]    m_stat, m_en;
  logic [3:0]    m_ovf;

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] head_of(int q);
    return (mdl_q[q].size() == 0) ? '1 : mdl_q[q][0];
  endfunction

  function automatic logic [DW-1:0] exp_rdata();
    if (!(req_valid && !req_write)) return '0;
    case (req_addr)
      3'd0: return req_host ? head_of(0) : '0;
      3'd1: return req_host ? head_of(2) : '0;
      3'd2: return req_host ? DW'(m_stat) : '0;
      3'd3: return DW'(m_en);
      3'd4: return m_msg[0];
      3'd5: return m_msg[1];
      3'd6: return DW'(m_ovf);
      default: return '0;
    endcase
  endfunction

  task automatic idle();
    req_valid = 0; req_write = 0; req_host = 0; req_addr = 0; req_wdata = 0;
    lp_ifree_push = 0; lp_ifree_data = 0; lp_opost_push = 0; lp_opost_data = 0;
    lp_ipost_pop = 0; lp_ofree_pop = 0;
  endtask

  task automatic hacc(bit wr, bit host, logic [2:0] a, logic [DW-1:0] d);
    req_valid = 1; req_write = wr; req_host = host; req_addr = a; req_wdata = d;
  endtask

  task automatic model_update();
    bit            rd, wr;
    bit            pop_req [4];
    bit            push_req [4];
    logic [DW-1:0] push_val [4];
    logic [3:0]    set_ovf;
    rd = req_valid && !req_write;
    wr = req_valid && req_write;
    pop_req[0]  = rd && req_host && req_addr == 0;
    push_req[0] = lp_ifree_push; push_val[0] = lp_ifree_data;
    push_req[1] = wr && req_host && req_addr == 0; push_val[1] = req_wdata;
    pop_req[1]  = lp_ipost_pop;
    push_req[2] = lp_opost_push; push_val[2] = lp_opost_data;
    pop_req[2]  = rd && req_host && req_addr == 1;
    push_req[3] = wr && req_host && req_addr == 1; push_val[3] = req_wdata;
    pop_req[3]  = lp_ofree_pop;
    set_ovf = '0;
    for (int q = 0; q < 4; q++) begin
      bit pop_ok, push_ok;
      pop_ok  = pop_req[q] && mdl_q[q].size() > 0;
      push_ok = push_req[q] && (mdl_q[q].size() < DEPTH || pop_ok);
      if (pop_ok)  void'(mdl_q[q].pop_front());
      if (push_ok) mdl_q[q].push_back(push_val[q]);
      if (push_req[q] && !push_ok) set_ovf[q] = 1'b1;
    end
    if (wr && req_addr == 6) m_ovf = m_ovf & ~req_wdata[3:0];
    m_ovf = m_ovf | set_ovf;
    if (wr && !req_host && req_addr == 4) begin m_msg[0] = req_wdata; m_stat[0] = 1'b1; end
    if (wr && !req_host && req_addr == 5) begin m_msg[1] = req_wdata; m_stat[1] = 1'b1; end
    if (wr && req_host && req_addr == 2) m_stat = m_stat & ~req_wdata[1:0];
    if (wr && req_addr == 3) m_en = req_wdata[1:0];
  endtask

  // compare every output, then advance model and clock
  task automatic step();
    #1;
    chk("rsp_rdata", rsp_rdata, exp_rdata());
    chk("lp_ipost_data", lp_ipost_data, head_of(1));
    chk("lp_ofree_data", lp_ofree_data, head_of(3));
    chk("lp_ipost_empty", DW'(lp_ipost_empty), DW'(mdl_q[1].size() == 0));
    chk("lp_ofree_empty", DW'(lp_ofree_empty), DW'(mdl_q[3].size() == 0));
    chk("lp_ifree_full", DW'(lp_ifree_full), DW'(mdl_q[0].size() == DEPTH));
    chk("lp_opost_full", DW'(lp_opost_full), DW'(mdl_q[2].size() == DEPTH));
    chk("host_irq", DW'(host_irq), DW'(|(m_stat & m_en)));
    model_update();
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL %s watchdog: actual hung expected done", cur_tag);
    finish_run();
  end

  initial begin
    idle();
    rst_n = 1'b0;
    m_msg[0] = '0; m_msg[1] = '0; m_stat = '0; m_en = 2'b11; m_ovf = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    cur_tag = "R1";
    step();
    hacc(0, 1, 3, 0); step();
    hacc(0, 1, 6, 0); step();
    hacc(0, 1, 2, 0); step();
    hacc(0, 1, 4, 0); step();
    hacc(0, 0, 5, 0); step();

    // R4: empty reads
    cur_tag = "R4";
    hacc(0, 1, 0, 0); lp_ipost_pop = 1; lp_ofree_pop = 1; step();
    hacc(0, 1, 1, 0); step();
    hacc(0, 1, 1, 0); step();

    // R2: inbound port
    cur_tag = "R2";
    for (int i = 0; i < 3; i++) begin lp_ifree_push = 1; lp_ifree_data = 32'h100 + i; step(); end
    for (int i = 0; i < 4; i++) begin hacc(0, 1, 0, 0); step(); end
    for (int i = 0; i < 3; i++) begin hacc(1, 1, 0, 32'h200 + i); step(); end
    for (int i = 0; i < 4; i++) begin lp_ipost_pop = 1; step(); end

    // R3: outbound port
    cur_tag = "R3";
    for (int i = 0; i < 3; i++) begin lp_opost_push = 1; lp_opost_data = 32'h1100 + i; step(); end
    for (int i = 0; i < 4; i++) begin hacc(0, 1, 1, 0); step(); end
    for (int i = 0; i < 3; i++) begin hacc(1, 1, 1, 32'h1200 + i); step(); end
    for (int i = 0; i < 4; i++) begin lp_ofree_pop = 1; step(); end

    // R5: overflow on full, sticky, write-one-to-clear
    cur_tag = "R5";
    for (int i = 0; i < 17; i++) begin lp_ifree_push = 1; lp_ifree_data = 32'h300 + i; step(); end
    hacc(0, 1, 6, 0); step();
    hacc(0, 0, 6, 0); step();
    hacc(1, 0, 6, 32'h1); step();
    hacc(0, 1, 6, 0); step();
    for (int i = 0; i < 17; i++) begin hacc(1, 1, 1, 32'h400 + i); step(); end
    hacc(0, 1, 6, 0); step();
    hacc(1, 1, 6, 32'h2); step();
    hacc(0, 1, 6, 0); step();
    hacc(1, 1, 6, 32'h8); step();
    hacc(0, 1, 6, 0); step();

    // R6: push and pop on one queue in the same cycle
    cur_tag = "R6";
    lp_ifree_push = 1; lp_ifree_data = 32'h555; hacc(0, 1, 0, 0); step();
    hacc(1, 1, 1, 32'h666); lp_ofree_pop = 1; step();
    hacc(0, 1, 6, 0); step();
    hacc(1, 1, 0, 32'h777); lp_ipost_pop = 1; step();
    lp_ipost_pop = 1; step();
    for (int i = 0; i < 17; i++) begin hacc(0, 1, 0, 0); step(); end
    for (int i = 0; i < 17; i++) begin lp_ofree_pop = 1; step(); end
    hacc(0, 1, 6, 0); step();

    // R7: local side cannot use host-only registers
    cur_tag = "R7";
    lp_opost_push = 1; lp_opost_data = 32'h888; step();
    hacc(0, 0, 1, 0); step();
    hacc(0, 1, 1, 0); step();
    hacc(1, 0, 0, 32'h999); step();
    hacc(1, 0, 1, 32'h99A); step();
    step();
    hacc(1, 0, 4, 32'hABCD0004); step();
    hacc(1, 0, 2, 32'h3); step();
    hacc(0, 0, 2, 0); step();
    hacc(0, 1, 2, 0); step();

    // R8: outbound message registers
    cur_tag = "R8";
    hacc(1, 0, 5, 32'hCAFE0005); step();
    hacc(0, 1, 5, 0); step();
    hacc(1, 1, 4, 32'h1234); step();
    hacc(0, 1, 4, 0); step();
    hacc(0, 0, 4, 0); step();
    hacc(0, 1, 2, 0); step();

    // R9: write-one-to-clear status
    cur_tag = "R9";
    hacc(1, 1, 2, 32'h0); step();
    hacc(0, 1, 2, 0); step();
    hacc(1, 1, 2, 32'h1); step();
    hacc(0, 1, 2, 0); step();
    hacc(1, 1, 2, 32'h2); step();
    hacc(0, 1, 2, 0); step();

    // R10: interrupt enable
    cur_tag = "R10";
    hacc(1, 0, 4, 32'h44); step();
    hacc(1, 1, 3, 32'h0); step();
    hacc(0, 0, 3, 0); step();
    hacc(1, 0, 3, 32'h2); step();
    hacc(1, 0, 3, 32'h1); step();
    hacc(1, 1, 2, 32'h1); step();
    hacc(1, 1, 3, 32'h3); step();

    // R11: order across wrap-around
    cur_tag = "R11";
    for (int i = 0; i < 40; i++) begin
      lp_opost_push = 1; lp_opost_data = 32'hA000 + i;
      if (i >= 3) hacc(0, 1, 1, 0);
      step();
    end
    for (int i = 0; i < 5; i++) begin hacc(0, 1, 1, 0); step(); end

    // R6: mixed traffic, overlapping host and local activity
    cur_tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      int bias;
      bias = (i / 500) % 3;
      req_valid = ($urandom % 2) == 0;
      req_write = $urandom % 2;
      req_host  = ($urandom % 4) != 0;
      req_addr  = 3'($urandom % 8);
      req_wdata = $urandom;
      lp_ifree_push = ($urandom % 3) < (bias == 0 ? 2 : 1);
      lp_ifree_data = $urandom;
      lp_opost_push = ($urandom % 3) < (bias == 1 ? 2 : 1);
      lp_opost_data = $urandom;
      lp_ipost_pop  = ($urandom % 3) < (bias == 2 ? 2 : 1);
      lp_ofree_pop  = ($urandom % 3) == 0;
      step();
    end

    finish_run();
  end
endmodule